// File: doc/BRIEF.md
# Partitioned Output Cell Buffer

This block is the cell store of one switch output port. A single 128-entry cell memory is carved into three first-in first-out queues of unequal size: 48 entries feed the even-numbered line, 48 feed the odd-numbered line, and 32 hold multicast cells that either line may carry. Arriving cells carry a two-bit queue tag. Each queue keeps its own occupancy count.

Every queue raises two backpressure flags, one guaranteed-class and one best-effort-class, when its occupancy is strictly above a programmable threshold. The two line queues share one pair of thresholds. The multicast queue has a separate pair. Upstream logic uses the flags to throttle cell entry. Toward the lines, each line takes one cell per cycle unless its stop input is high. A line drains its own queue first and takes a multicast cell only when that queue is empty. The multicast queue alternates between the two lines.

Top module: `port_cell_store`

## Requirements
- R1: Capacity is partitioned as 48 cells for the even queue, 48 for the odd queue and 32 for the multicast queue, and each queue delivers its cells in arrival order.
- R2: `wr_queue` selects the target queue: 0 is the even line, 1 is the odd line, 2 is multicast, and 3 discards the cell with no change to any queue or output.
- R3: A write to a queue that already holds its full capacity is discarded and drives `overflow_err` high for the one cycle after that write's clock edge. Cells already stored are unaffected.
- R4: For each line queue, `bp_*_best` is high when occupancy > the line best-effort threshold (reset value 24), and `bp_*_guar` is high when occupancy > the line guaranteed threshold (reset value 32). Each flag follows an occupancy change one clock later.
- R5: The multicast flags `bp_mc_guar` and `bp_mc_best` compare the multicast occupancy strictly against their own thresholds, which reset to 16 and 8.
- R6: A pulse on `thr_load` writes `thr_value` into the threshold chosen by `thr_sel`: 0 is line guaranteed, 1 is line best-effort, 2 is multicast guaranteed, 3 is multicast best-effort. A value above the limit is clamped to the limit, which is 48 for line thresholds and 32 for multicast thresholds.
- R7: While a line's stop input is high, that line's output valid is low from the next cycle on, and no cell meant for that line is lost.
- R8: On a given line, cells from that line's own queue are delivered before any multicast cell.
- R9: Multicast cells go to the even and odd lines in turn, starting with the even line after reset. A line that cannot accept a cell is skipped, and the other line takes the cell.
- R10: A cell removed from a queue appears on the line output, with valid high, in the cycle after the removal edge. At most one cell per line is delivered in a cycle.
- R11: After reset all queues are empty, all flags and `overflow_err` are low, and both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A cell is offered this cycle |
| wr_queue | input | 2 | Target queue tag |
| wr_cell | input | CELL_W | Cell word |
| stop_even | input | 1 | Halts delivery to the even line |
| stop_odd | input | 1 | Halts delivery to the odd line |
| thr_load | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Which threshold to write |
| thr_value | input | 8 | Threshold value before clamping |
| out_even_valid | output | 1 | Even-line cell valid |
| out_even_cell | output | CELL_W | Even-line cell |
| out_odd_valid | output | 1 | Odd-line cell valid |
| out_odd_cell | output | CELL_W | Odd-line cell |
| bp_even_guar | output | 1 | Even queue over guaranteed threshold |
| bp_even_best | output | 1 | Even queue over best-effort threshold |
| bp_odd_guar | output | 1 | Odd queue over guaranteed threshold |
| bp_odd_best | output | 1 | Odd queue over best-effort threshold |
| bp_mc_guar | output | 1 | Multicast queue over guaranteed threshold |
| bp_mc_best | output | 1 | Multicast queue over best-effort threshold |
| overflow_err | output | 1 | One-cycle pulse for a discarded write to a full queue |

## Verification
The hardest states to reach are the exact threshold edges and a completely full queue. Delivery never pauses on its own, so a queue can only be filled to a chosen level by holding its line's stop input high while cells are written one at a time. The flags are read one cycle after each level is reached: at 24 and 25 cells, at 32 and 33, and at 48 cells followed by one extra write that must be refused. The multicast ordering is tested by holding both lines stopped while multicast cells collect. The two stops are then released together, and in a second case only one stop is released, which shows that the alternation skips a line that cannot accept a cell.

// File: rtl/port_cell_pkg.sv
package port_cell_pkg;

  localparam int THR_W = 8;

  typedef enum logic [1:0] {
    QSEL_EVEN = 2'd0,
    QSEL_ODD  = 2'd1,
    QSEL_MC   = 2'd2,
    QSEL_NONE = 2'd3
  } qsel_e;

  typedef enum logic [1:0] {
    TSEL_LINE_G = 2'd0,
    TSEL_LINE_B = 2'd1,
    TSEL_MC_G   = 2'd2,
    TSEL_MC_B   = 2'd3
  } tsel_e;

  typedef enum logic {
    TURN_EVEN = 1'b0,
    TURN_ODD  = 1'b1
  } turn_e;

  // Limit a requested threshold to the legal maximum of its class.
  function automatic int unsigned clamp_thr(int unsigned req, int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

  // Backpressure rule: strictly above the threshold.
  function automatic logic exceeds(int unsigned occ, int unsigned thr);
    return occ > thr;
  endfunction

endpackage

// File: rtl/pcs_queue_ctrl.sv
module pcs_queue_ctrl #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8,
  parameter int BASE   = 0,
  parameter int DEPTH  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic              accept,
  output logic              drop,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] FIRST   = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(BASE + DEPTH - 1);
  localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);

  function automatic logic [ADDR_W-1:0] advance(logic [ADDR_W-1:0] a);
    return (a == LAST) ? FIRST : a + 1'b1;
  endfunction

  assign full   = (count == DEPTH_C);
  assign empty  = (count == '0);
  assign accept = push_req && !full;
  assign drop   = push_req && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      wr_addr <= FIRST;
      rd_addr <= FIRST;
    end else begin
      if (accept) wr_addr <= advance(wr_addr);
      if (pop)    rd_addr <= advance(rd_addr);
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> full);

  assert_pop_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_ptr_in_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= FIRST) && (rd_addr <= LAST) && (wr_addr >= FIRST) && (wr_addr <= LAST));
endmodule

// File: rtl/pcs_thresholds.sv
module pcs_thresholds
  import port_cell_pkg::*;
#(
  parameter int LINE_MAX   = 48,
  parameter int MC_MAX     = 32,
  parameter int LINE_G_RST = 32,
  parameter int LINE_B_RST = 24,
  parameter int MC_G_RST   = 16,
  parameter int MC_B_RST   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       sel,
  input  logic [THR_W-1:0] value,
  output logic [THR_W-1:0] line_g,
  output logic [THR_W-1:0] line_b,
  output logic [THR_W-1:0] mc_g,
  output logic [THR_W-1:0] mc_b
);
  logic [THR_W-1:0] line_val, mc_val;

  assign line_val = THR_W'(clamp_thr(int'(value), LINE_MAX));
  assign mc_val   = THR_W'(clamp_thr(int'(value), MC_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_g <= THR_W'(LINE_G_RST);
      line_b <= THR_W'(LINE_B_RST);
      mc_g   <= THR_W'(MC_G_RST);
      mc_b   <= THR_W'(MC_B_RST);
    end else if (load) begin
      case (tsel_e'(sel))
        TSEL_LINE_G: line_g <= line_val;
        TSEL_LINE_B: line_b <= line_val;
        TSEL_MC_G:   mc_g   <= mc_val;
        default:     mc_b   <= mc_val;
      endcase
    end
  end

  assert_line_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_g <= THR_W'(LINE_MAX)) && (line_b <= THR_W'(LINE_MAX)));

  assert_mc_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_g <= THR_W'(MC_MAX)) && (mc_b <= THR_W'(MC_MAX)));

  assert_hold_unloaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(line_g) && $stable(line_b) && $stable(mc_g) && $stable(mc_b));
endmodule

// File: rtl/pcs_bp_flags.sv
module pcs_bp_flags
  import port_cell_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr_g,
  input  logic [THR_W-1:0] thr_b,
  output logic             bp_g,
  output logic             bp_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_g <= 1'b0;
      bp_b <= 1'b0;
    end else begin
      bp_g <= exceeds(int'(count), int'(thr_g));
      bp_b <= exceeds(int'(count), int'(thr_b));
    end
  end

  assert_empty_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (!bp_g && !bp_b));
endmodule

// File: rtl/pcs_drain_arb.sv
module pcs_drain_arb
  import port_cell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_even,
  input  logic stop_odd,
  input  logic even_empty,
  input  logic odd_empty,
  input  logic mc_empty,
  output logic pop_even,
  output logic pop_odd,
  output logic pop_mc,
  output logic mc_to_even,
  output logic mc_to_odd
);
  turn_e turn;
  logic  even_mc_ok, odd_mc_ok;

  assign pop_even   = !stop_even && !even_empty;
  assign pop_odd    = !stop_odd && !odd_empty;
  assign even_mc_ok = !stop_even && even_empty && !mc_empty;
  assign odd_mc_ok  = !stop_odd && odd_empty && !mc_empty;
  assign mc_to_even = even_mc_ok && (turn == TURN_EVEN || !odd_mc_ok);
  assign mc_to_odd  = odd_mc_ok && !mc_to_even;
  assign pop_mc     = mc_to_even || mc_to_odd;

  always_ff @(posedge clk) begin
    if (!rst_n)          turn <= TURN_EVEN;
    else if (mc_to_even) turn <= TURN_ODD;
    else if (mc_to_odd)  turn <= TURN_EVEN;
  end

  assert_mc_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mc_to_even, mc_to_odd}));

  assert_mc_turn_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mc_to_even |=> (turn == TURN_ODD));
endmodule

// File: rtl/port_cell_store.sv
module port_cell_store
  import port_cell_pkg::*;
#(
  parameter int CELL_W     = 16,
  parameter int EVEN_DEPTH = 48,
  parameter int ODD_DEPTH  = 48,
  parameter int MC_DEPTH   = 32,
  parameter int LINE_G_RST = 32,
  parameter int LINE_B_RST = 24,
  parameter int MC_G_RST   = 16,
  parameter int MC_B_RST   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_queue,
  input  logic [CELL_W-1:0] wr_cell,
  input  logic              stop_even,
  input  logic              stop_odd,
  input  logic              thr_load,
  input  logic [1:0]        thr_sel,
  input  logic [THR_W-1:0]  thr_value,
  output logic              out_even_valid,
  output logic [CELL_W-1:0] out_even_cell,
  output logic              out_odd_valid,
  output logic [CELL_W-1:0] out_odd_cell,
  output logic              bp_even_guar,
  output logic              bp_even_best,
  output logic              bp_odd_guar,
  output logic              bp_odd_best,
  output logic              bp_mc_guar,
  output logic              bp_mc_best,
  output logic              overflow_err
);
  localparam int NQ     = 3;
  localparam int TOTAL  = EVEN_DEPTH + ODD_DEPTH + MC_DEPTH;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int LINE_MAX = (EVEN_DEPTH > ODD_DEPTH) ? EVEN_DEPTH : ODD_DEPTH;

  function automatic int q_depth(int q);
    return (q == 0) ? EVEN_DEPTH : (q == 1) ? ODD_DEPTH : MC_DEPTH;
  endfunction

  function automatic int q_base(int q);
    return (q == 0) ? 0 : (q == 1) ? EVEN_DEPTH : EVEN_DEPTH + ODD_DEPTH;
  endfunction

  logic [NQ-1:0]     push_req, pop, full, empty, accept, drop, bp_g, bp_b;
  logic [CNT_W-1:0]  count   [NQ];
  logic [ADDR_W-1:0] wr_addr [NQ];
  logic [ADDR_W-1:0] rd_addr [NQ];
  logic [CELL_W-1:0] mem     [TOTAL];

  logic [THR_W-1:0] thr_line_g, thr_line_b, thr_mc_g, thr_mc_b;
  logic             mc_to_even, mc_to_odd;

  pcs_thresholds #(
    .LINE_MAX(LINE_MAX), .MC_MAX(MC_DEPTH),
    .LINE_G_RST(LINE_G_RST), .LINE_B_RST(LINE_B_RST),
    .MC_G_RST(MC_G_RST), .MC_B_RST(MC_B_RST)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .load(thr_load), .sel(thr_sel), .value(thr_value),
    .line_g(thr_line_g), .line_b(thr_line_b), .mc_g(thr_mc_g), .mc_b(thr_mc_b)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    assign push_req[q] = wr_valid && (wr_queue == 2'(q));

    pcs_queue_ctrl #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE(q_base(q)), .DEPTH(q_depth(q))
    ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .push_req(push_req[q]), .pop(pop[q]),
      .full(full[q]), .empty(empty[q]), .accept(accept[q]), .drop(drop[q]),
      .count(count[q]), .wr_addr(wr_addr[q]), .rd_addr(rd_addr[q])
    );

    if (q == NQ - 1) begin : g_mc_thr
      pcs_bp_flags #(.CNT_W(CNT_W)) u_bp (
        .clk(clk), .rst_n(rst_n), .count(count[q]),
        .thr_g(thr_mc_g), .thr_b(thr_mc_b), .bp_g(bp_g[q]), .bp_b(bp_b[q])
      );
    end else begin : g_line_thr
      pcs_bp_flags #(.CNT_W(CNT_W)) u_bp (
        .clk(clk), .rst_n(rst_n), .count(count[q]),
        .thr_g(thr_line_g), .thr_b(thr_line_b), .bp_g(bp_g[q]), .bp_b(bp_b[q])
      );
    end
  end

  pcs_drain_arb u_arb (
    .clk(clk), .rst_n(rst_n), .stop_even(stop_even), .stop_odd(stop_odd),
    .even_empty(empty[0]), .odd_empty(empty[1]), .mc_empty(empty[2]),
    .pop_even(pop[0]), .pop_odd(pop[1]), .pop_mc(pop[2]),
    .mc_to_even(mc_to_even), .mc_to_odd(mc_to_odd)
  );

  // Shared store: at most one queue accepts in a cycle because the tag is one value.
  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (accept[q]) mem[wr_addr[q]] <= wr_cell;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_even_valid <= 1'b0;
      out_odd_valid  <= 1'b0;
      out_even_cell  <= '0;
      out_odd_cell   <= '0;
      overflow_err   <= 1'b0;
    end else begin
      out_even_valid <= pop[0] || mc_to_even;
      out_odd_valid  <= pop[1] || mc_to_odd;
      if (pop[0])          out_even_cell <= mem[rd_addr[0]];
      else if (mc_to_even) out_even_cell <= mem[rd_addr[2]];
      if (pop[1])          out_odd_cell  <= mem[rd_addr[1]];
      else if (mc_to_odd)  out_odd_cell  <= mem[rd_addr[2]];
      overflow_err <= |drop;
    end
  end

  assign bp_even_guar = bp_g[0];
  assign bp_even_best = bp_b[0];
  assign bp_odd_guar  = bp_g[1];
  assign bp_odd_best  = bp_b[1];
  assign bp_mc_guar   = bp_g[2];
  assign bp_mc_best   = bp_b[2];

  assert_stop_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_even |=> !out_even_valid);

  assert_stop_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_odd |=> !out_odd_valid);

  assert_own_before_mc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty[0] && !stop_even) |-> !mc_to_even);

  assert_ignored_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_queue == QSEL_NONE) |-> (accept == '0 && drop == '0));

  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop) |=> overflow_err);
endmodule

// File: tb/port_cell_store_bench.sv
module port_cell_store_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [1:0]  wr_queue;
  logic [15:0] wr_cell;
  logic        stop_even, stop_odd;
  logic        thr_load;
  logic [1:0]  thr_sel;
  logic [7:0]  thr_value;
  logic        out_even_valid, out_odd_valid;
  logic [15:0] out_even_cell, out_odd_cell;
  logic        bp_even_guar, bp_even_best, bp_odd_guar, bp_odd_best;
  logic        bp_mc_guar, bp_mc_best, overflow_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  port_cell_store u_port_cell_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_queue(wr_queue), .wr_cell(wr_cell),
    .stop_even(stop_even), .stop_odd(stop_odd), .thr_load(thr_load), .thr_sel(thr_sel),
    .thr_value(thr_value), .out_even_valid(out_even_valid), .out_even_cell(out_even_cell),
    .out_odd_valid(out_odd_valid), .out_odd_cell(out_odd_cell),
    .bp_even_guar(bp_even_guar), .bp_even_best(bp_even_best),
    .bp_odd_guar(bp_odd_guar), .bp_odd_best(bp_odd_best),
    .bp_mc_guar(bp_mc_guar), .bp_mc_best(bp_mc_best), .overflow_err(overflow_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; wr_queue = 2'd0; wr_cell = '0;
    stop_even = 1'b1; stop_odd = 1'b1; thr_load = 1'b0; thr_sel = 2'd0; thr_value = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [1:0] q, input logic [15:0] c);
    wr_valid = 1'b1; wr_queue = q; wr_cell = c;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_thr(input logic [1:0] s, input logic [7:0] v);
    thr_load = 1'b1; thr_sel = s; thr_value = v;
    @(negedge clk);
    thr_load = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R11 even valid", out_even_valid, 0);
    chk("R11 odd valid", out_odd_valid, 0);
    chk("R11 flags", {bp_even_guar, bp_even_best, bp_odd_guar, bp_odd_best, bp_mc_guar, bp_mc_best}, 0);
    chk("R11 overflow", overflow_err, 0);
  endtask

  // Even queue: threshold edges, full refusal, stop hold, FIFO order.
  task automatic t_even_fill();
    do_reset();
    for (int i = 0; i < 24; i++) put(2'd0, 16'h1000 + 16'(i));
    @(negedge clk);
    chk("R4 best at 24", bp_even_best, 0);
    put(2'd0, 16'h1000 + 16'd24);
    @(negedge clk);
    chk("R4 best at 25", bp_even_best, 1);
    chk("R4 guar at 25", bp_even_guar, 0);
    for (int i = 25; i < 32; i++) put(2'd0, 16'h1000 + 16'(i));
    @(negedge clk);
    chk("R4 guar at 32", bp_even_guar, 0);
    put(2'd0, 16'h1000 + 16'd32);
    chk("R4 guar lags one cycle", bp_even_guar, 0);
    @(negedge clk);
    chk("R4 guar at 33", bp_even_guar, 1);
    chk("R4 odd flags independent", {bp_odd_guar, bp_odd_best}, 0);
    for (int i = 33; i < 48; i++) put(2'd0, 16'h1000 + 16'(i));
    chk("R3 no error below full", overflow_err, 0);
    put(2'd0, 16'hDEAD);
    chk("R3 overflow pulse", overflow_err, 1);
    @(negedge clk);
    chk("R3 pulse single cycle", overflow_err, 0);
    chk("R7 stopped even valid", out_even_valid, 0);
    stop_even = 1'b0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      chk("R10 even valid during drain", out_even_valid, 1);
      chk("R1 even FIFO order", out_even_cell, 16'h1000 + i);
    end
    @(negedge clk);
    chk("R1 even holds exactly 48", out_even_valid, 0);
    chk("R4 flags clear after drain", {bp_even_guar, bp_even_best}, 0);
  endtask

  // Odd queue fill and the discard tag.
  task automatic t_odd_and_discard();
    do_reset();
    stop_even = 1'b0;
    for (int i = 0; i < 25; i++) put(2'd1, 16'h2000 + 16'(i));
    @(negedge clk);
    chk("R4 odd best at 25", bp_odd_best, 1);
    chk("R4 odd guar at 25", bp_odd_guar, 0);
    chk("R2 odd cells not on even line", out_even_valid, 0);
    stop_odd = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk("R1 odd FIFO order", out_odd_cell, 16'h2000 + i);
    end
    @(negedge clk);
    put(2'd3, 16'hBEEF);
    chk("R2 discard tag no error", overflow_err, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2 discard even quiet", out_even_valid, 0);
      chk("R2 discard odd quiet", out_odd_valid, 0);
      @(negedge clk);
    end
    chk("R2 discard no flags", {bp_even_best, bp_odd_best, bp_mc_best}, 0);
  endtask

  // Multicast flags, capacity and alternation.
  task automatic t_mc();
    do_reset();
    for (int i = 0; i < 8; i++) put(2'd2, 16'h3000 + 16'(i));
    @(negedge clk);
    chk("R5 mc best at 8", bp_mc_best, 0);
    for (int i = 8; i < 16; i++) put(2'd2, 16'h3000 + 16'(i));
    @(negedge clk);
    chk("R5 mc best at 16", bp_mc_best, 1);
    chk("R5 mc guar at 16", bp_mc_guar, 0);
    put(2'd2, 16'h3000 + 16'd16);
    @(negedge clk);
    chk("R5 mc guar at 17", bp_mc_guar, 1);
    for (int i = 17; i < 32; i++) put(2'd2, 16'h3000 + 16'(i));
    put(2'd2, 16'hDEAD);
    chk("R3 mc overflow at 33rd", overflow_err, 1);
    stop_even = 1'b0; stop_odd = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (i % 2 == 0) begin
        chk("R9 even turn valid", out_even_valid, 1);
        chk("R9 even turn cell", out_even_cell, 16'h3000 + i);
        chk("R10 one mc per cycle", out_odd_valid, 0);
      end else begin
        chk("R9 odd turn valid", out_odd_valid, 1);
        chk("R9 odd turn cell", out_odd_cell, 16'h3000 + i);
        chk("R10 one mc per cycle", out_even_valid, 0);
      end
    end
    @(negedge clk);
    chk("R1 mc holds exactly 32", out_even_valid | out_odd_valid, 0);
  endtask

  // Skip a stopped line in the alternation.
  task automatic t_mc_skip();
    do_reset();
    put(2'd2, 16'h4000);
    put(2'd2, 16'h4001);
    stop_even = 1'b0;
    @(negedge clk);
    chk("R9 skip first", out_even_cell, 16'h4000);
    @(negedge clk);
    chk("R9 skip stopped odd", out_even_valid, 1);
    chk("R9 skip second cell", out_even_cell, 16'h4001);
    chk("R7 odd stays quiet", out_odd_valid, 0);
  endtask

  // Own queue before multicast.
  task automatic t_priority();
    do_reset();
    put(2'd2, 16'h5C01);
    put(2'd0, 16'h5E01);
    put(2'd0, 16'h5E02);
    stop_even = 1'b0;
    @(negedge clk);
    chk("R8 own first", out_even_cell, 16'h5E01);
    @(negedge clk);
    chk("R8 own second", out_even_cell, 16'h5E02);
    @(negedge clk);
    chk("R8 mc after own valid", out_even_valid, 1);
    chk("R8 mc after own cell", out_even_cell, 16'h5C01);
    chk("R7 odd not fed while stopped", out_odd_valid, 0);
  endtask

  // Threshold loading and clamping.
  task automatic t_thresholds();
    do_reset();
    load_thr(2'd0, 8'd200);
    for (int i = 0; i < 48; i++) put(2'd0, 16'(i));
    @(negedge clk);
    chk("R6 clamped line guar at 48", bp_even_guar, 0);
    load_thr(2'd0, 8'd47);
    @(negedge clk);
    chk("R6 line guar 47", bp_even_guar, 1);
    load_thr(2'd1, 8'd0);
    put(2'd1, 16'h0001);
    @(negedge clk);
    chk("R6 shared line best 0 odd", bp_odd_best, 1);
    load_thr(2'd3, 8'd99);
    for (int i = 0; i < 32; i++) put(2'd2, 16'(i));
    @(negedge clk);
    chk("R6 clamped mc best at 32", bp_mc_best, 0);
    load_thr(2'd2, 8'd31);
    @(negedge clk);
    chk("R6 mc guar 31", bp_mc_guar, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_queue = '0; wr_cell = '0;
    stop_even = 1'b1; stop_odd = 1'b1; thr_load = 1'b0; thr_sel = '0; thr_value = '0;
    t_reset_state();
    t_even_fill();
    t_odd_and_discard();
    t_mc();
    t_mc_skip();
    t_priority();
    t_thresholds();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule